// File: doc/BRIEF.md
# DRAM ECC Error Logger

This block sits next to the SECDED decoder of a DRAM controller and keeps a software-visible record of memory errors. Every clock cycle the decoder may report a correctable (single-bit) event, an uncorrectable (double-bit) event, or both. Each event is accompanied by the failing 64-bit address, a 10-bit Hamming syndrome, the bank, the logical and physical rank, and an 8-bit edge bitmap. The block counts both kinds of event in saturating 16-bit counters and raises a sticky flag for each kind. It also holds one error record in a capture stage.

A control register selects the capture policy. In keep-last mode every event overwrites the record. In keep-first mode the first event is held until software re-arms capture by clearing a flag. The capture stage cannot be read directly. Software sets a start bit, which copies the captured record into a set of readable info registers. Those registers then stay stable while software reads them field by field. All access goes through a simple 32-bit register bus. Reads are combinational and writes take effect on the clock edge. The flag register is write-one-to-clear, and clearing a flag also zeroes the matching counter.

Register map (byte offsets): 0x00 counts, 0x04 flags, 0x08 control, 0x0C syndrome/type, 0x10 address low word, 0x14 address high word, 0x18 location info. All other offsets read as zero.

Top module: `ecc_err_logger`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero.
- R2: Register 0x00 holds the single-bit event count in bits 15:0 and the double-bit event count in bits 31:16. Each cycle with the matching event input high adds one.
- R3: Each counter saturates at 0xFFFF and never wraps.
- R4: Register 0x04 has a sticky single flag at bit 0 and a sticky double flag at bit 16. A flag is set in the cycle after its event.
- R5: Writing 1 to flag bit 0 clears the single flag and the single counter. Writing 1 to bit 16 clears the double flag and the double counter. Zero bits have no effect. When an event arrives in the same cycle as its clear, the clear applies first, leaving the counter at 1 and the flag set.
- R6: With control bit 0 equal to 0 (keep-last), every event overwrites the captured record.
- R7: With control bit 0 equal to 1 (keep-first), the captured record is held once taken. It can be replaced only by an event in or after a cycle in which a flag-register write clears bit 0 or bit 16.
- R8: The record stores the error type as double (syndrome register bit 0) or single (bit 1). When both events arrive in one cycle, the type is double only.
- R9: Writing control bit 24 as 1 copies the record as it stood before that edge into the info registers. The info registers change at no other time, and bit 24 reads as 0.
- R10: Info layout: register 0x0C holds the type bits and the syndrome in bits 25:16. Register 0x10 holds address bits 31:0 and register 0x14 holds address bits 63:32. Register 0x18 holds the bank in 3:0, the logical rank in 5:4, the physical rank in 9:8 and the edge bitmap in 23:16.
- R11: Reserved bits read 0. Writes to 0x00, 0x0C, 0x10, 0x14, 0x18 and unmapped offsets have no effect. Control keeps only bit 0 and the 4-bit edge-select field in bits 19:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_single | input | 1 | Decoder reports a corrected single-bit error this cycle |
| ev_double | input | 1 | Decoder reports an uncorrectable double-bit error this cycle |
| ev_addr | input | 64 | Failing address |
| ev_syndrome | input | 10 | Hamming syndrome of the failing word |
| ev_bank | input | 4 | Failing bank |
| ev_lrank | input | 2 | Failing logical rank |
| ev_prank | input | 2 | Failing physical rank |
| ev_edge | input | 8 | Edge bitmap of the failing beat |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |

## Verification
The bench runs every combination of the two event inputs under both capture policies. It mixes in start writes and partial flag clears, some of them in the same cycle as an event. This separates the keep-first and keep-last behaviour, shows the double-over-single type priority, and shows that a start copies the record from before the edge, not the one just arriving. A run of more than 65,535 back-to-back events, with both kinds asserted, tells saturation apart from wrap-around. Follow-up clears of one flag at a time confirm that each clear touches only its own counter. All-ones writes to the read-only registers, the control register and unmapped offsets, together with a flag write holding only reserved bits, confirm that reserved bits and read-only registers ignore stimulus.

// File: rtl/ecc_log_pkg.sv
// Package: shared register offsets, field positions and enums for the
// DRAM ECC error logger. Assumes a byte-addressed 32-bit register bus.
package ecc_log_pkg;

    localparam int REG_AW = 8;
    localparam int REG_DW = 32;

    localparam logic [REG_AW-1:0] OFS_COUNT   = 8'h00;
    localparam logic [REG_AW-1:0] OFS_FLAGS   = 8'h04;
    localparam logic [REG_AW-1:0] OFS_CTRL    = 8'h08;
    localparam logic [REG_AW-1:0] OFS_SYND    = 8'h0C;
    localparam logic [REG_AW-1:0] OFS_ADDR_LO = 8'h10;
    localparam logic [REG_AW-1:0] OFS_ADDR_HI = 8'h14;
    localparam logic [REG_AW-1:0] OFS_INFO    = 8'h18;

    localparam int FLG_SINGLE_BIT = 0;
    localparam int FLG_DOUBLE_BIT = 16;
    localparam int CNT_DOUBLE_LSB = 16;

    localparam int CTL_POLICY_BIT = 0;
    localparam int CTL_ESEL_LSB   = 16;
    localparam int CTL_START_BIT  = 24;

    localparam int SYN_DERR_BIT   = 0;
    localparam int SYN_SERR_BIT   = 1;
    localparam int SYN_FIELD_LSB  = 16;

    localparam int INF_BANK_LSB   = 0;
    localparam int INF_LRANK_LSB  = 4;
    localparam int INF_PRANK_LSB  = 8;
    localparam int INF_EDGE_LSB   = 16;

    typedef enum logic {
        KIND_SINGLE = 1'b0,
        KIND_DOUBLE = 1'b1
    } err_kind_e;

    localparam int NUM_KINDS = 2;

    typedef enum logic {
        POL_KEEP_LAST  = 1'b0,
        POL_KEEP_FIRST = 1'b1
    } cap_policy_e;

endpackage

// File: rtl/ecc_err_tally.sv
// Module: per-kind error tally. Keeps a saturating event counter and a
// sticky flag. Assumes clr and hit are single-cycle qualified strobes;
// a clear in the same cycle as a hit is applied before the hit.
module ecc_err_tally #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             hit,
    output logic [CNT_W-1:0] count,
    output logic             flag
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] nxt;

    // Next count: clear first, then a saturating increment.
    always_comb begin
        base = clr ? '0 : count;
        nxt  = (hit && (base != CNT_MAX)) ? base + 1'b1 : base;
    end

    // State update for counter and sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            flag  <= 1'b0;
        end else begin
            count <= nxt;
            flag  <= hit | (flag & ~clr);
        end
    end

endmodule

// File: rtl/ecc_capture.sv
// Module: capture stage for one error record. In keep-last mode any event
// loads the record; in keep-first mode only an event arriving while the
// stage is empty or being re-armed does. Double beats single on type.
// Assumes the detail inputs belong to whichever event is reported.
module ecc_capture #(
    parameter int ADDR_W  = 64,
    parameter int SYN_W   = 10,
    parameter int BANK_W  = 4,
    parameter int LRANK_W = 2,
    parameter int PRANK_W = 2,
    parameter int EDGE_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_single,
    input  logic               ev_double,
    input  logic               keep_first,
    input  logic               rearm,
    input  logic [ADDR_W-1:0]  in_addr,
    input  logic [SYN_W-1:0]   in_syn,
    input  logic [BANK_W-1:0]  in_bank,
    input  logic [LRANK_W-1:0] in_lrank,
    input  logic [PRANK_W-1:0] in_prank,
    input  logic [EDGE_W-1:0]  in_edge,
    output logic [ADDR_W-1:0]  cap_addr,
    output logic [SYN_W-1:0]   cap_syn,
    output logic               cap_derr,
    output logic               cap_serr,
    output logic [BANK_W-1:0]  cap_bank,
    output logic [LRANK_W-1:0] cap_lrank,
    output logic [PRANK_W-1:0] cap_prank,
    output logic [EDGE_W-1:0]  cap_edge,
    output logic               cap_valid
);

    logic any_ev;
    logic armed;
    logic take;

    // Decide whether this cycle's event replaces the record.
    always_comb begin
        any_ev = ev_single | ev_double;
        armed  = rearm | ~cap_valid;
        take   = any_ev & (~keep_first | armed);
    end

    // Load the record and track whether it holds an error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr  <= '0;
            cap_syn   <= '0;
            cap_derr  <= 1'b0;
            cap_serr  <= 1'b0;
            cap_bank  <= '0;
            cap_lrank <= '0;
            cap_prank <= '0;
            cap_edge  <= '0;
            cap_valid <= 1'b0;
        end else begin
            if (take) begin
                cap_addr  <= in_addr;
                cap_syn   <= in_syn;
                cap_derr  <= ev_double;
                cap_serr  <= ev_single & ~ev_double;
                cap_bank  <= in_bank;
                cap_lrank <= in_lrank;
                cap_prank <= in_prank;
                cap_edge  <= in_edge;
            end
            cap_valid <= any_ev | (cap_valid & ~rearm);
        end
    end

endmodule

// File: rtl/ecc_info_shadow.sv
// Module: readable copy of the capture record. Loads the packed record on
// a load strobe and holds it otherwise. Assumes load is one cycle wide.
module ecc_info_shadow #(
    parameter int VEC_W = 92
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [VEC_W-1:0] in_vec,
    output logic [VEC_W-1:0] out_vec
);

    // Hold register, updated only by the start strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vec <= '0;
        end else if (load) begin
            out_vec <= in_vec;
        end
    end

endmodule

// File: rtl/ecc_log_regs.sv
// Module: register bus front end. Decodes writes into clear, re-arm and
// start strobes, holds the control fields, and builds the read word.
// Assumes byte offsets, 32-bit data and combinational reads.
module ecc_log_regs
    import ecc_log_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int SYN_W   = 10,
    parameter int BANK_W  = 4,
    parameter int LRANK_W = 2,
    parameter int PRANK_W = 2,
    parameter int EDGE_W  = 8,
    parameter int CNT_W   = 16,
    parameter int ESEL_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [REG_AW-1:0]  bus_addr,
    input  logic [REG_DW-1:0]  bus_wdata,
    output logic [REG_DW-1:0]  bus_rdata,
    input  logic [CNT_W-1:0]   cnt_single,
    input  logic [CNT_W-1:0]   cnt_double,
    input  logic               flag_single,
    input  logic               flag_double,
    input  logic [ADDR_W-1:0]  sh_addr,
    input  logic [SYN_W-1:0]   sh_syn,
    input  logic               sh_derr,
    input  logic               sh_serr,
    input  logic [BANK_W-1:0]  sh_bank,
    input  logic [LRANK_W-1:0] sh_lrank,
    input  logic [PRANK_W-1:0] sh_prank,
    input  logic [EDGE_W-1:0]  sh_edge,
    output logic               clr_single,
    output logic               clr_double,
    output logic               rearm,
    output logic               start_load,
    output logic               keep_first
);

    localparam int ADDR_HI_W = ADDR_W - 32;

    logic              wr_hit;
    logic [ESEL_W-1:0] edge_sel;
    cap_policy_e       policy;

    // Write strobes decoded from the bus.
    always_comb begin
        wr_hit     = bus_sel & bus_wr;
        clr_single = wr_hit && (bus_addr == OFS_FLAGS) && bus_wdata[FLG_SINGLE_BIT];
        clr_double = wr_hit && (bus_addr == OFS_FLAGS) && bus_wdata[FLG_DOUBLE_BIT];
        rearm      = clr_single | clr_double;
        start_load = wr_hit && (bus_addr == OFS_CTRL) && bus_wdata[CTL_START_BIT];
        keep_first = (policy == POL_KEEP_FIRST);
    end

    // Control register: capture policy and edge-select field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            policy   <= POL_KEEP_LAST;
            edge_sel <= '0;
        end else if (wr_hit && (bus_addr == OFS_CTRL)) begin
            policy   <= cap_policy_e'(bus_wdata[CTL_POLICY_BIT]);
            edge_sel <= bus_wdata[CTL_ESEL_LSB +: ESEL_W];
        end
    end

    // Read multiplexer; reserved bits and unmapped offsets return zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_COUNT: begin
                bus_rdata[CNT_W-1:0]              = cnt_single;
                bus_rdata[CNT_DOUBLE_LSB +: CNT_W] = cnt_double;
            end
            OFS_FLAGS: begin
                bus_rdata[FLG_SINGLE_BIT] = flag_single;
                bus_rdata[FLG_DOUBLE_BIT] = flag_double;
            end
            OFS_CTRL: begin
                bus_rdata[CTL_POLICY_BIT]          = keep_first;
                bus_rdata[CTL_ESEL_LSB +: ESEL_W]  = edge_sel;
            end
            OFS_SYND: begin
                bus_rdata[SYN_DERR_BIT]            = sh_derr;
                bus_rdata[SYN_SERR_BIT]            = sh_serr;
                bus_rdata[SYN_FIELD_LSB +: SYN_W]  = sh_syn;
            end
            OFS_ADDR_LO: bus_rdata = sh_addr[31:0];
            OFS_ADDR_HI: bus_rdata[ADDR_HI_W-1:0] = sh_addr[ADDR_W-1:32];
            OFS_INFO: begin
                bus_rdata[INF_BANK_LSB +: BANK_W]   = sh_bank;
                bus_rdata[INF_LRANK_LSB +: LRANK_W] = sh_lrank;
                bus_rdata[INF_PRANK_LSB +: PRANK_W] = sh_prank;
                bus_rdata[INF_EDGE_LSB +: EDGE_W]   = sh_edge;
            end
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ecc_err_logger.sv
// Module: DRAM ECC error logger top. Counts single and double decoder
// events, keeps sticky flags, captures one error record under a
// selectable policy and exposes a start-loaded copy on a register bus.
// Assumes one set of detail inputs shared by both event kinds.
module ecc_err_logger
    import ecc_log_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int SYN_W   = 10,
    parameter int BANK_W  = 4,
    parameter int LRANK_W = 2,
    parameter int PRANK_W = 2,
    parameter int EDGE_W  = 8,
    parameter int CNT_W   = 16,
    parameter int ESEL_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_single,
    input  logic               ev_double,
    input  logic [ADDR_W-1:0]  ev_addr,
    input  logic [SYN_W-1:0]   ev_syndrome,
    input  logic [BANK_W-1:0]  ev_bank,
    input  logic [LRANK_W-1:0] ev_lrank,
    input  logic [PRANK_W-1:0] ev_prank,
    input  logic [EDGE_W-1:0]  ev_edge,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [REG_AW-1:0]  bus_addr,
    input  logic [REG_DW-1:0]  bus_wdata,
    output logic [REG_DW-1:0]  bus_rdata
);

    localparam int REC_W = ADDR_W + SYN_W + 2 + BANK_W + LRANK_W + PRANK_W + EDGE_W;

    logic [NUM_KINDS-1:0] kind_hit;
    logic [NUM_KINDS-1:0] kind_clr;
    logic [NUM_KINDS-1:0] kind_flag;
    logic [CNT_W-1:0]     kind_cnt [NUM_KINDS];

    logic [CNT_W-1:0] cnt_s;
    logic [CNT_W-1:0] cnt_d;
    logic             flag_s;
    logic             flag_d;
    logic             clr_s;
    logic             clr_d;
    logic             rearm;
    logic             start_load;
    logic             keep_first;

    logic [ADDR_W-1:0]  cap_addr;
    logic [SYN_W-1:0]   cap_syn;
    logic               cap_derr;
    logic               cap_serr;
    logic [BANK_W-1:0]  cap_bank;
    logic [LRANK_W-1:0] cap_lrank;
    logic [PRANK_W-1:0] cap_prank;
    logic [EDGE_W-1:0]  cap_edge;
    logic               cap_valid;

    logic [REC_W-1:0] rec_in;
    logic [REC_W-1:0] sh_out;

    logic [ADDR_W-1:0]  sh_addr;
    logic [SYN_W-1:0]   sh_syn;
    logic               sh_derr;
    logic               sh_serr;
    logic [BANK_W-1:0]  sh_bank;
    logic [LRANK_W-1:0] sh_lrank;
    logic [PRANK_W-1:0] sh_prank;
    logic [EDGE_W-1:0]  sh_edge;

    // Route event and clear strobes to the per-kind tallies.
    always_comb begin
        kind_hit[KIND_SINGLE] = ev_single;
        kind_hit[KIND_DOUBLE] = ev_double;
        kind_clr[KIND_SINGLE] = clr_s;
        kind_clr[KIND_DOUBLE] = clr_d;
        cnt_s  = kind_cnt[KIND_SINGLE];
        cnt_d  = kind_cnt[KIND_DOUBLE];
        flag_s = kind_flag[KIND_SINGLE];
        flag_d = kind_flag[KIND_DOUBLE];
    end

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_tally
        ecc_err_tally #(.CNT_W(CNT_W)) u_tally (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (kind_clr[k]),
            .hit   (kind_hit[k]),
            .count (kind_cnt[k]),
            .flag  (kind_flag[k])
        );
    end

    ecc_capture #(
        .ADDR_W(ADDR_W), .SYN_W(SYN_W), .BANK_W(BANK_W),
        .LRANK_W(LRANK_W), .PRANK_W(PRANK_W), .EDGE_W(EDGE_W)
    ) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_single  (ev_single),
        .ev_double  (ev_double),
        .keep_first (keep_first),
        .rearm      (rearm),
        .in_addr    (ev_addr),
        .in_syn     (ev_syndrome),
        .in_bank    (ev_bank),
        .in_lrank   (ev_lrank),
        .in_prank   (ev_prank),
        .in_edge    (ev_edge),
        .cap_addr   (cap_addr),
        .cap_syn    (cap_syn),
        .cap_derr   (cap_derr),
        .cap_serr   (cap_serr),
        .cap_bank   (cap_bank),
        .cap_lrank  (cap_lrank),
        .cap_prank  (cap_prank),
        .cap_edge   (cap_edge),
        .cap_valid  (cap_valid)
    );

    // Pack the record for the shadow and unpack its copy.
    always_comb begin
        rec_in = {cap_addr, cap_syn, cap_derr, cap_serr,
                  cap_bank, cap_lrank, cap_prank, cap_edge};
        {sh_addr, sh_syn, sh_derr, sh_serr,
         sh_bank, sh_lrank, sh_prank, sh_edge} = sh_out;
    end

    ecc_info_shadow #(.VEC_W(REC_W)) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start_load),
        .in_vec  (rec_in),
        .out_vec (sh_out)
    );

    ecc_log_regs #(
        .ADDR_W(ADDR_W), .SYN_W(SYN_W), .BANK_W(BANK_W),
        .LRANK_W(LRANK_W), .PRANK_W(PRANK_W), .EDGE_W(EDGE_W),
        .CNT_W(CNT_W), .ESEL_W(ESEL_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .cnt_single  (cnt_s),
        .cnt_double  (cnt_d),
        .flag_single (flag_s),
        .flag_double (flag_d),
        .sh_addr     (sh_addr),
        .sh_syn      (sh_syn),
        .sh_derr     (sh_derr),
        .sh_serr     (sh_serr),
        .sh_bank     (sh_bank),
        .sh_lrank    (sh_lrank),
        .sh_prank    (sh_prank),
        .sh_edge     (sh_edge),
        .clr_single  (clr_s),
        .clr_double  (clr_d),
        .rearm       (rearm),
        .start_load  (start_load),
        .keep_first  (keep_first)
    );

endmodule

// File: rtl/ecc_err_logger_chk.sv
// Module: property checker for the ECC error logger, bound to the top.
// Assumes it sees the bus ports and the top's internal tally, capture
// and shadow signals.
module ecc_err_logger_chk
    import ecc_log_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 64,
    parameter int REC_W  = 92
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_single,
    input logic              ev_double,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [REG_AW-1:0] bus_addr,
    input logic [REG_DW-1:0] bus_wdata,
    input logic [CNT_W-1:0]  cnt_s,
    input logic [CNT_W-1:0]  cnt_d,
    input logic              flag_s,
    input logic              flag_d,
    input logic              keep_first,
    input logic              cap_valid,
    input logic [ADDR_W-1:0] cap_addr,
    input logic [REC_W-1:0]  sh_out
);

    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic wr_flags;
    logic w_clr_s;
    logic w_clr_d;
    logic w_start;

    // Bus-side view of clears and start, taken from the ports.
    always_comb begin
        wr_flags = bus_sel && bus_wr && (bus_addr == OFS_FLAGS);
        w_clr_s  = wr_flags && bus_wdata[FLG_SINGLE_BIT];
        w_clr_d  = wr_flags && bus_wdata[FLG_DOUBLE_BIT];
        w_start  = bus_sel && bus_wr && (bus_addr == OFS_CTRL) && bus_wdata[CTL_START_BIT];
    end

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_single && !w_clr_s && cnt_s != CMAX) |=> (cnt_s == $past(cnt_s) + 1'b1)); // R2
    AST_DOUBLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_double && !w_clr_d && cnt_d != CMAX) |=> (cnt_d == $past(cnt_d) + 1'b1)); // R2
    AST_SINGLE_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_s == CMAX && !w_clr_s) |=> (cnt_s == CMAX)); // R3
    AST_DOUBLE_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (!w_clr_d) |=> (cnt_d >= $past(cnt_d))); // R3
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_single || (flag_s && !w_clr_s)) |=> flag_s); // R4
    AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (w_clr_d && !ev_double) |=> (!flag_d && cnt_d == '0)); // R5
    AST_FIRST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (keep_first && cap_valid && !w_clr_s && !w_clr_d) |=> $stable(cap_addr)); // R7
    AST_INFO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!w_start) |=> $stable(sh_out)); // R9

endmodule

bind ecc_err_logger ecc_err_logger_chk #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .REC_W(REC_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_single  (ev_single),
    .ev_double  (ev_double),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .cnt_s      (cnt_s),
    .cnt_d      (cnt_d),
    .flag_s     (flag_s),
    .flag_d     (flag_d),
    .keep_first (keep_first),
    .cap_valid  (cap_valid),
    .cap_addr   (cap_addr),
    .sh_out     (sh_out)
);

// File: tb/tb_ecc_err_logger.sv
`timescale 1ns/100ps
module tb_ecc_err_logger;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_single = 1'b0, ev_double = 1'b0;
    logic [63:0] ev_addr = '0;
    logic [9:0]  ev_syndrome = '0;
    logic [3:0]  ev_bank = '0;
    logic [1:0]  ev_lrank = '0, ev_prank = '0;
    logic [7:0]  ev_edge = '0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_chk = 0;
    int n_bad = 0;

    // Reference model state
    logic [15:0] m_cs = '0, m_cd = '0;
    logic        m_fs = 0, m_fd = 0, m_pol = 0, m_cv = 0;
    logic [3:0]  m_esel = '0;
    logic [63:0] c_addr = '0, s_addr = '0;
    logic [9:0]  c_syn = '0, s_syn = '0;
    logic        c_d = 0, c_s = 0, s_d = 0, s_s = 0;
    logic [3:0]  c_bk = '0, s_bk = '0;
    logic [1:0]  c_lr = '0, s_lr = '0, c_pr = '0, s_pr = '0;
    logic [7:0]  c_eg = '0, s_eg = '0;

    always #10 clk = ~clk;

    ecc_err_logger dut (
        .clk(clk), .rst_n(rst_n),
        .ev_single(ev_single), .ev_double(ev_double),
        .ev_addr(ev_addr), .ev_syndrome(ev_syndrome),
        .ev_bank(ev_bank), .ev_lrank(ev_lrank), .ev_prank(ev_prank),
        .ev_edge(ev_edge),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run hung got=running exp=finished");
        summary();
        $finish;
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #0.5 v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    // One clock with events and an optional write; model follows the requirements.
    task automatic tick(input logic s, input logic d, input logic wr,
                        input logic [7:0] wa, input logic [31:0] wd, input int seed);
        logic clr_s, clr_d, rearm, start, take;
        ev_single = s; ev_double = d;
        ev_addr = {32'(seed) * 32'h9E3779B9, ~(32'(seed) * 32'h01010101)};
        ev_syndrome = 10'(seed * 37 + 5);
        ev_bank = 4'(seed); ev_lrank = 2'(seed >> 1); ev_prank = 2'(seed >> 2);
        ev_edge = 8'(1 << (seed % 8));
        bus_sel = wr; bus_wr = wr; bus_addr = wa; bus_wdata = wd;
        @(posedge clk);
        clr_s = wr && wa == 8'h04 && wd[0];
        clr_d = wr && wa == 8'h04 && wd[16];
        rearm = clr_s || clr_d;
        start = wr && wa == 8'h08 && wd[24];
        if (start) begin // R9: copy of the record before this edge
            s_addr = c_addr; s_syn = c_syn; s_d = c_d; s_s = c_s;
            s_bk = c_bk; s_lr = c_lr; s_pr = c_pr; s_eg = c_eg;
        end
        take = (s || d) && (!m_pol || rearm || !m_cv); // R6 R7
        if (take) begin
            c_addr = ev_addr; c_syn = ev_syndrome; c_d = d; c_s = s && !d; // R8
            c_bk = ev_bank; c_lr = ev_lrank; c_pr = ev_prank; c_eg = ev_edge;
        end
        m_cv = s || d || (m_cv && !rearm);
        if (clr_s) m_cs = '0;
        if (clr_d) m_cd = '0;
        if (s && m_cs != 16'hFFFF) m_cs = m_cs + 1'b1;
        if (d && m_cd != 16'hFFFF) m_cd = m_cd + 1'b1;
        m_fs = s || (m_fs && !clr_s);
        m_fd = d || (m_fd && !clr_d);
        if (wr && wa == 8'h08) begin m_pol = wd[0]; m_esel = wd[19:16]; end
        @(negedge clk);
        ev_single = 0; ev_double = 0; bus_sel = 0; bus_wr = 0;
    endtask

    task automatic check_all(input string ctx);
        logic [31:0] v;
        @(negedge clk);
        rd(8'h00, v); check({ctx, " R2 R3 counts"}, v, {m_cd, m_cs});
        rd(8'h04, v); check({ctx, " R4 R5 flags"}, v, {15'b0, m_fd, 15'b0, m_fs});
        rd(8'h08, v); check({ctx, " R11 control"}, v, {12'b0, m_esel, 15'b0, m_pol});
        rd(8'h0C, v); check({ctx, " R8 R10 syndrome"}, v, {6'b0, s_syn, 14'b0, s_s, s_d});
        rd(8'h10, v); check({ctx, " R6 R7 R10 addr lo"}, v, s_addr[31:0]);
        rd(8'h14, v); check({ctx, " R6 R7 R10 addr hi"}, v, s_addr[63:32]);
        rd(8'h18, v); check({ctx, " R9 R10 info"}, v, {8'b0, s_eg, 6'b0, s_pr, 2'b0, s_lr, s_bk});
        rd(8'h1C, v); check({ctx, " R11 unmapped"}, v, 32'h0);
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset");

        // Sweep every event pattern under both policies, mixing starts and clears.
        for (int pol = 0; pol < 2; pol++) begin
            tick(0, 0, 1, 8'h08, 32'(pol), 0);
            for (int i = 0; i < 48; i++) begin
                if (i % 6 == 5)
                    tick(i[0], i[1], 1, 8'h08, {7'b0, 1'b1, 4'b0, 4'(i), 15'b0, 1'(pol)}, i + 100 * pol);
                else if (i % 7 == 6)
                    tick(i[0], i[1], 1, 8'h04, {15'b0, i[3], 15'b0, i[2]}, i + 100 * pol);
                else
                    tick(i[0], i[1], 0, 8'h00, 32'h0, i + 100 * pol);
                check_all(pol == 0 ? "R6 sweep" : "R7 sweep");
            end
        end

        // R7: keep-first holds event A against B until re-armed
        tick(0, 0, 1, 8'h08, 32'h1, 0);
        tick(0, 0, 1, 8'h04, 32'h0001_0001, 0);
        tick(1, 0, 0, 8'h00, 0, 201);
        tick(0, 1, 0, 8'h00, 0, 202);
        tick(0, 0, 1, 8'h08, 32'h0100_0001, 0);
        rd(8'h10, v); check("R7 first kept addr lo", v, 32'(201) * 32'h9E3779B9 ^ 32'h0 ? ~(32'(201) * 32'h01010101) : 32'h0);
        check_all("R7 first kept");

        // R8: both at once under keep-last
        tick(0, 0, 1, 8'h08, 32'h0, 0);
        tick(1, 1, 0, 8'h00, 0, 303);
        tick(0, 0, 1, 8'h08, 32'h0100_0000, 0);
        rd(8'h0C, v); check("R8 both-at-once type", {30'b0, v[1:0]}, 32'h1);

        // R3: saturation of both counters
        tick(0, 0, 1, 8'h04, 32'h0001_0001, 0);
        for (int i = 0; i < 65540; i++) tick(1, 1, 0, 8'h00, 0, i);
        rd(8'h00, v); check("R3 saturated", v, 32'hFFFF_FFFF);
        check_all("R3 saturation");

        // R5: clear single only, then clear with a same-cycle event
        tick(0, 0, 1, 8'h04, 32'h0000_0001, 0);
        rd(8'h00, v); check("R5 single cleared double kept", v, 32'hFFFF_0000);
        tick(1, 0, 1, 8'h04, 32'h0001_0001, 7);
        rd(8'h00, v); check("R5 clear then count", v, 32'h0000_0001);
        check_all("R5 same-cycle");
        tick(0, 0, 1, 8'h04, 32'hFFFE_FFFE, 0);
        check_all("R5 zero bits ignored");

        // R11: writes to read-only and unmapped offsets, all-ones control
        tick(0, 0, 1, 8'h00, 32'hFFFF_FFFF, 0);
        tick(0, 0, 1, 8'h0C, 32'hFFFF_FFFF, 0);
        tick(0, 0, 1, 8'h10, 32'hFFFF_FFFF, 0);
        tick(0, 0, 1, 8'h14, 32'hFFFF_FFFF, 0);
        tick(0, 0, 1, 8'h18, 32'hFFFF_FFFF, 0);
        tick(0, 0, 1, 8'h1C, 32'hFFFF_FFFF, 0);
        check_all("R11 read-only writes");
        tick(0, 0, 1, 8'h08, 32'hFFFF_FFFF, 0);
        rd(8'h08, v); check("R11 R9 control readback", v, 32'h000F_0001);
        check_all("R11 control");

        summary();
        $finish;
    end

endmodule